// File: doc/BRIEF.md
# Match-Compare System Timer with Deferred Register Transfers

This block is a system timer attached to a simple register bus. It has a 32-bit up-counter that can be started and stopped, one committed compare value, a sticky match flag, an interrupt mask bit and a level interrupt output. Software drives it through single-cycle read and write strobes, a byte offset and a 32-bit data word.

Access to the live counter and to the compare value is deferred. A counter value becomes readable only after software asks for a capture through the control register and the capture completes. New compare values and new counter values take effect only after a fixed transfer delay. While any of these three transfers is in flight, its busy bit in a read-only transfer-status register is 1, so software can poll until the transfer has finished. Read data is registered: the word selected by a read strobe appears on the read-data port in the cycle after the strobe and holds until the next read.

Register offsets: compare 0x00, counter 0x10, match flags 0x14, interrupt mask 0x1C, control 0x20, transfer status 0x24. The transfer delay is the parameter `XFER_LAT`, 4 clocks by default.

Top module: `mtimer_top`

## Requirements
- R1: After reset the captured counter, the match flag, the mask register, the control register and the transfer-status register read 0, the compare register reads 0xFFFFFFFF and `irq` is 0.
- R2: While control bit 0 is 1, the live counter increases by one on every clock and wraps from 0xFFFFFFFF to 0. While control bit 0 is 0, the counter holds its value.
- R3: A control write stores bits 7:2 and bit 0. Bit 1 is never stored and reads 0, and bits 31:8 read 0. A control write with bit 1 set requests a counter capture.
- R4: A capture takes the value the live counter holds in the cycle of the request write. The reads issued in the next `XFER_LAT` cycles show transfer-status bit 5 as 1. After that, offset 0x10 returns the captured value.
- R5: A write to offset 0x00 takes effect as the compare value `XFER_LAT` cycles later. Transfer-status bit 0 is 1 in between. Reads of offset 0x00 return the compare value currently in effect.
- R6: A write to offset 0x10 loads the live counter `XFER_LAT` cycles later. Transfer-status bit 4 is 1 in between. The load wins over counting in that cycle.
- R7: Match flag bit 0 at offset 0x14 becomes 1 in the cycle after the live counter equals the compare value in effect. It then stays 1 until it is cleared.
- R8: Writing 1 to bit 0 of offset 0x14 clears the match flag. If an equality occurs in the same cycle, the flag stays 1. Bits 3:1 of offset 0x14 read 0.
- R9: `irq` is 1 exactly when the match flag and mask bit 0 (offset 0x1C) are both 1. Only mask bit 0 is stored.
- R10: Reads of unmapped offsets return 0. Writes to unmapped offsets, and writes to the transfer-status register, change no register.
- R11: `bus_rdata` changes only in the cycle after a read strobe, and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bus logic and the counter |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is a flag clear that arrives in the same cycle as a fresh equality between counter and compare value. A running counter passes the compare point for only one clock, and bus writes are hard to place that precisely. The bench instead stops the counter on the compare value, so the equality holds in every cycle, and then issues the clear. It then moves the counter away and clears again, to show that the clear itself works. The exact cycle in which the flag rises is measured separately, by starting the counter a known number of steps below the compare value and sampling `irq` after each clock.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

    localparam int ADDR_W      = 8;
    localparam int TMR_W       = 32;
    localparam int CTRL_KEEP_W = 8;
    localparam int NXFER       = 3;

    // transfer channel indices
    localparam int XF_MATCH = 0;
    localparam int XF_CWR   = 1;
    localparam int XF_SNAP  = 2;

    // register offsets
    localparam logic [ADDR_W-1:0] OFF_MATCH = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_COUNT = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_IEN   = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_BUSY  = 8'h24;

    // bit positions
    localparam int CTRL_RUN  = 0;
    localparam int CTRL_SNAP = 1;
    localparam int BSY_MATCH = 0;
    localparam int BSY_CWR   = 4;
    localparam int BSY_SNAP  = 5;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MATCH,
        SEL_COUNT,
        SEL_STAT,
        SEL_IEN,
        SEL_CTRL,
        SEL_BUSY
    } reg_sel_e;

    typedef struct packed {
        logic                   wr;
        logic                   rd;
        reg_sel_e               sel;
        logic [CTRL_KEEP_W-1:0] wlo;
    } bus_req_t;

    function automatic reg_sel_e decode_off(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFF_MATCH: s = SEL_MATCH;
            OFF_COUNT: s = SEL_COUNT;
            OFF_STAT:  s = SEL_STAT;
            OFF_IEN:   s = SEL_IEN;
            OFF_CTRL:  s = SEL_CTRL;
            OFF_BUSY:  s = SEL_BUSY;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/mtimer_xfer.sv
module mtimer_xfer
    import mtimer_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [TMR_W-1:0] din,
    output logic             busy,
    output logic             commit,
    output logic [TMR_W-1:0] dout
);

    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0]    left_q;
    logic [TMR_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            data_q <= '0;
        end else if (start) begin
            left_q <= CW'(LAT);
            data_q <= din;
        end else if (left_q != '0) begin
            left_q <= left_q - CW'(1);
        end
    end

    assign busy   = (left_q != '0);
    assign commit = (left_q == CW'(1)) && !start;
    assign dout   = data_q;

endmodule

// File: rtl/mtimer_core.sv
module mtimer_core
    import mtimer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    input  logic             match_ld,
    input  logic [TMR_W-1:0] match_in,
    output logic [TMR_W-1:0] cnt,
    output logic [TMR_W-1:0] match,
    output logic             hit
);

    logic [TMR_W-1:0] cnt_q;
    logic [TMR_W-1:0] match_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run) begin
            cnt_q <= cnt_q + TMR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= '1;
        end else if (match_ld) begin
            match_q <= match_in;
        end
    end

    assign cnt   = cnt_q;
    assign match = match_q;
    assign hit   = (cnt_q == match_q);

endmodule

// File: rtl/mtimer_regs.sv
module mtimer_regs
    import mtimer_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [CTRL_KEEP_W-1:0] wdata_lo,
    input  logic                   hit,
    input  logic [TMR_W-1:0]       match_val,
    input  logic                   snap_commit,
    input  logic [TMR_W-1:0]       snap_data,
    input  logic [NXFER-1:0]       xf_busy,
    output logic [NXFER-1:0]       xf_start,
    output logic                   run,
    output logic                   stat,
    output logic                   ien,
    output logic [TMR_W-1:0]       snap,
    output logic                   irq,
    output logic [TMR_W-1:0]       rdata
);

    bus_req_t req;

    logic [CTRL_KEEP_W-1:0] ctrl_q;
    logic                   stat_q;
    logic                   ien_q;
    logic [TMR_W-1:0]       snap_q;
    logic [TMR_W-1:0]       rdata_q;
    logic [TMR_W-1:0]       rd_word;
    logic [TMR_W-1:0]       busy_word;

    always_comb begin
        req.wr  = bus_wr;
        req.rd  = bus_rd;
        req.sel = decode_off(bus_addr);
        req.wlo = wdata_lo;
    end

    always_comb begin
        xf_start            = '0;
        xf_start[XF_MATCH]  = req.wr && (req.sel == SEL_MATCH);
        xf_start[XF_CWR]    = req.wr && (req.sel == SEL_COUNT);
        xf_start[XF_SNAP]   = req.wr && (req.sel == SEL_CTRL) && req.wlo[CTRL_SNAP];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (req.wr && (req.sel == SEL_CTRL)) begin
            ctrl_q <= req.wlo & ~(CTRL_KEEP_W'(1) << CTRL_SNAP);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q <= 1'b0;
        end else if (req.wr && (req.sel == SEL_IEN)) begin
            ien_q <= req.wlo[0];
        end
    end

    // set takes precedence over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= 1'b0;
        end else if (hit) begin
            stat_q <= 1'b1;
        end else if (req.wr && (req.sel == SEL_STAT) && req.wlo[0]) begin
            stat_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
        end else if (snap_commit) begin
            snap_q <= snap_data;
        end
    end

    always_comb begin
        busy_word            = '0;
        busy_word[BSY_MATCH] = xf_busy[XF_MATCH];
        busy_word[BSY_CWR]   = xf_busy[XF_CWR];
        busy_word[BSY_SNAP]  = xf_busy[XF_SNAP];
    end

    always_comb begin
        case (req.sel)
            SEL_MATCH: rd_word = match_val;
            SEL_COUNT: rd_word = snap_q;
            SEL_STAT:  rd_word = TMR_W'(stat_q);
            SEL_IEN:   rd_word = TMR_W'(ien_q);
            SEL_CTRL:  rd_word = TMR_W'(ctrl_q);
            SEL_BUSY:  rd_word = busy_word;
            default:   rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (req.rd) begin
            rdata_q <= rd_word;
        end
    end

    assign run   = ctrl_q[CTRL_RUN];
    assign stat  = stat_q;
    assign ien   = ien_q;
    assign snap  = snap_q;
    assign irq   = stat_q & ien_q;
    assign rdata = rdata_q;

endmodule

// File: rtl/mtimer_top.sv
module mtimer_top
    import mtimer_pkg::*;
#(
    parameter int XFER_LAT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [TMR_W-1:0]  bus_wdata,
    output logic [TMR_W-1:0]  bus_rdata,
    output logic              irq
);

    logic [NXFER-1:0] xf_start;
    logic [NXFER-1:0] xf_busy;
    logic [NXFER-1:0] xf_commit;
    logic [TMR_W-1:0] xf_din  [NXFER];
    logic [TMR_W-1:0] xf_dout [NXFER];

    logic [TMR_W-1:0] live_cnt;
    logic [TMR_W-1:0] match_val;
    logic [TMR_W-1:0] snap_val;
    logic             hit;
    logic             run_en;
    logic             stat_flag;
    logic             ien_flag;
    logic             cnt_load;

    assign xf_din[XF_MATCH] = bus_wdata;
    assign xf_din[XF_CWR]   = bus_wdata;
    assign xf_din[XF_SNAP]  = live_cnt;
    assign cnt_load         = xf_commit[XF_CWR];

    for (genvar i = 0; i < NXFER; i++) begin : g_xfer
        mtimer_xfer #(.LAT(XFER_LAT)) u_xfer (
            .clk    (clk),
            .rst    (rst),
            .start  (xf_start[i]),
            .din    (xf_din[i]),
            .busy   (xf_busy[i]),
            .commit (xf_commit[i]),
            .dout   (xf_dout[i])
        );
    end

    mtimer_core u_core (
        .clk      (clk),
        .rst      (rst),
        .run      (run_en),
        .load     (cnt_load),
        .load_val (xf_dout[XF_CWR]),
        .match_ld (xf_commit[XF_MATCH]),
        .match_in (xf_dout[XF_MATCH]),
        .cnt      (live_cnt),
        .match    (match_val),
        .hit      (hit)
    );

    mtimer_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .wdata_lo    (bus_wdata[CTRL_KEEP_W-1:0]),
        .hit         (hit),
        .match_val   (match_val),
        .snap_commit (xf_commit[XF_SNAP]),
        .snap_data   (xf_dout[XF_SNAP]),
        .xf_busy     (xf_busy),
        .xf_start    (xf_start),
        .run         (run_en),
        .stat        (stat_flag),
        .ien         (ien_flag),
        .snap        (snap_val),
        .irq         (irq),
        .rdata       (bus_rdata)
    );

endmodule

// File: rtl/mtimer_chk.sv
module mtimer_chk
    import mtimer_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wbit0,
    input logic              wbit1,
    input logic [TMR_W-1:0]  bus_rdata,
    input logic              irq,
    input logic [TMR_W-1:0]  cnt,
    input logic [TMR_W-1:0]  match,
    input logic [TMR_W-1:0]  snap,
    input logic              stat,
    input logic              ien,
    input logic              run,
    input logic              load,
    input logic [NXFER-1:0]  busy
);

    logic unmapped;
    assign unmapped = (decode_off(bus_addr) == SEL_NONE);

    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        run && !load |=> cnt == $past(cnt) + TMR_W'(1));

    p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !run && !load |=> cnt == $past(cnt));

    p_snap_req_r3: assert property (@(posedge clk) disable iff (rst)
        bus_wr && (bus_addr == OFF_CTRL) && wbit1 |=> busy[XF_SNAP]);

    p_snap_gated_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(snap) |-> $past(busy[XF_SNAP]));

    p_match_gated_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(match) |-> $past(busy[XF_MATCH]));

    p_load_gated_r6: assert property (@(posedge clk) disable iff (rst)
        load |-> busy[XF_CWR]);

    p_hit_sets_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt == match) |=> stat);

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        stat && !(bus_wr && (bus_addr == OFF_STAT) && wbit0) |=> stat);

    p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> ien && stat);

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
        bus_rd && unmapped |=> bus_rdata == '0);

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

endmodule

bind mtimer_top mtimer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .wbit0     (bus_wdata[0]),
    .wbit1     (bus_wdata[1]),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .cnt       (live_cnt),
    .match     (match_val),
    .snap      (snap_val),
    .stat      (stat_flag),
    .ien       (ien_flag),
    .run       (run_en),
    .load      (cnt_load),
    .busy      (xf_busy)
);

// File: tb/mtimer_top_test.sv
module mtimer_top_test;
    import mtimer_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [TMR_W-1:0]  bus_wdata = '0;
    logic [TMR_W-1:0]  bus_rdata;
    logic              irq;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mtimer_top #(.XFER_LAT(LAT)) uut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // each access task consumes exactly one rising edge, entering and leaving at a falling edge
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(OFF_COUNT, v); chk("R1 count", v, 32'h0);
        rd(OFF_MATCH, v); chk("R1 match", v, 32'hFFFF_FFFF);
        rd(OFF_STAT,  v); chk("R1 stat",  v, 32'h0);
        rd(OFF_IEN,   v); chk("R1 ien",   v, 32'h0);
        rd(OFF_CTRL,  v); chk("R1 ctrl",  v, 32'h0);
        rd(OFF_BUSY,  v); chk("R1 busy",  v, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_ctrl_bits;
        logic [31:0] v;
        wr(OFF_CTRL, 32'hFFFF_FFFC);
        rd(OFF_CTRL, v); chk("R3 kept bits", v, 32'h0000_00FC);
        rd(OFF_BUSY, v); chk("R3 no capture without bit1", v, 32'h0);
        wr(OFF_CTRL, 32'h0);
    endtask

    task automatic t_load_and_capture;
        logic [31:0] v;
        wr(OFF_COUNT, 32'd100);
        for (int i = 0; i < LAT; i++) begin
            rd(OFF_BUSY, v); chk("R6 load busy", v, 32'h10);
        end
        rd(OFF_BUSY, v); chk("R6 load done", v, 32'h0);
        wr(OFF_CTRL, 32'h2);
        for (int i = 0; i < LAT; i++) begin
            rd(OFF_BUSY, v); chk("R4 capture busy", v, 32'h20);
        end
        rd(OFF_COUNT, v); chk("R4 captured value", v, 32'd100);
        rd(OFF_CTRL, v); chk("R3 bit1 not stored", v, 32'h0);
    endtask

    task automatic t_run;
        logic [31:0] v;
        wr(OFF_CTRL, 32'h1);
        wr(OFF_CTRL, 32'h3);
        for (int i = 0; i < LAT; i++) begin
            rd(OFF_BUSY, v); chk("R4 busy while running", v, 32'h20);
        end
        rd(OFF_COUNT, v); chk("R4 value at request cycle", v, 32'd100);
        wr(OFF_CTRL, 32'h0);
        wr(OFF_CTRL, 32'h2);
        idle(LAT);
        rd(OFF_COUNT, v); chk("R2 counted steps", v, 32'd107);
        // wrap
        wr(OFF_COUNT, 32'hFFFF_FFFD);
        idle(LAT);
        wr(OFF_CTRL, 32'h1);
        idle(4);
        wr(OFF_CTRL, 32'h0);
        wr(OFF_CTRL, 32'h2);
        idle(LAT);
        rd(OFF_COUNT, v); chk("R2 wrap", v, 32'h2);
    endtask

    task automatic t_flag_and_mask;
        logic [31:0] v;
        rd(OFF_STAT, v); chk("R7 flag set by passing compare", v, 32'h1);
        chk("R9 masked irq", {31'h0, irq}, 32'h0);
        wr(OFF_IEN, 32'hFFFF_FFFF);
        chk("R9 irq on", {31'h0, irq}, 32'h1);
        rd(OFF_IEN, v); chk("R9 mask bit only", v, 32'h1);
        wr(OFF_STAT, 32'hE);
        rd(OFF_STAT, v); chk("R8 bit0 clear needs bit0", v, 32'h1);
        wr(OFF_STAT, 32'h1);
        rd(OFF_STAT, v); chk("R8 cleared", v, 32'h0);
        chk("R9 irq off", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_match_write;
        logic [31:0] v;
        wr(OFF_MATCH, 32'h2);
        for (int i = 0; i < LAT; i++) begin
            rd(OFF_BUSY, v); chk("R5 match busy", v, 32'h1);
            chk("R5 no early compare", {31'h0, irq}, 32'h0);
        end
        idle(1);
        chk("R7 flag after commit", {31'h0, irq}, 32'h1);
        rd(OFF_MATCH, v); chk("R5 match readback", v, 32'h2);
        // clear while equality persists: set wins
        wr(OFF_STAT, 32'hF);
        rd(OFF_STAT, v); chk("R8 set beats clear", v, 32'h1);
        wr(OFF_COUNT, 32'd10);
        idle(LAT);
        wr(OFF_STAT, 32'hF);
        rd(OFF_STAT, v); chk("R8 clear after move", v, 32'h0);
    endtask

    task automatic t_exact_hit;
        logic [31:0] v;
        wr(OFF_MATCH, 32'd15);
        idle(LAT);
        wr(OFF_CTRL, 32'h1);
        for (int i = 0; i < 5; i++) begin
            idle(1);
            chk("R7 before equality", {31'h0, irq}, 32'h0);
        end
        idle(1);
        chk("R7 rise cycle", {31'h0, irq}, 32'h1);
        wr(OFF_CTRL, 32'h0);
        idle(3);
        rd(OFF_STAT, v); chk("R7 sticky", v, 32'h1);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        wr(8'h04, 32'hFFFF_FFFF);
        wr(OFF_BUSY, 32'hFFFF_FFFF);
        wr(8'h80, 32'hFFFF_FFFF);
        rd(8'h04, v); chk("R10 read 04", v, 32'h0);
        rd(8'h18, v); chk("R10 read 18", v, 32'h0);
        rd(OFF_BUSY, v); chk("R10 busy untouched", v, 32'h0);
        rd(OFF_CTRL, v); chk("R10 ctrl untouched", v, 32'h0);
        rd(OFF_IEN, v); chk("R10 ien untouched", v, 32'h1);
        rd(OFF_MATCH, v); chk("R10 match untouched", v, 32'd15);
        wr(OFF_IEN, 32'h0);
        idle(2);
        chk("R11 rdata holds", bus_rdata, 32'd15);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ctrl_bits();
        t_load_and_capture();
        t_run();
        t_flag_and_mask();
        t_match_write();
        t_exact_hit();
        t_unmapped();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule